// File: doc/BRIEF.md
# Point-to-point serial bus master

This block is the master end of a two-party serial link. The link uses SMBus start, stop, repeated-start and byte framing. Its wires are not open-drain. Each wire has exactly one driver: the master drives a clock line and a data-out line, and the slave drives a data-in line and one sideband line. The slave can never become master, so the block contains no arbitration logic.

A local controller drives the block with one-cycle commands. It can open a transaction (START), reopen one that is already open (repeated START), send a byte (WRITE), fetch a byte (READ), or close the transaction (STOP). A one-cycle `done` pulse reports completion. The pulse comes with the received byte and the acknowledge status.

The sideband line has two meanings:
- **While a transaction is open**, it is a clock-extension request. The master keeps the clock low and pauses its sequencing until the line is released.
- **While the bus is idle**, it is an alert from the slave. The alert is latched into a sticky interrupt flag, which the controller clears by writing one.

Top module: `ptp_smb_master`

## Requirements
- R1: While reset is held, and at the first idle cycle after reset, `bus_clk` and `bus_dout` are high and `busy`, `done` and `alert_irq` are low.
- R2: Command codes on `cmd_op` are 1 = START, 2 = STOP, 3 = WRITE and 4 = READ. A START issued while the bus is idle makes the following sequence:
  - `bus_dout` falls while `bus_clk` is high.
  - `bus_clk` then falls.
  - The command completes with `bus_clk` low and the transaction open.
- R3: Each low and each high phase of `bus_clk` inside a byte lasts `half_period` system clocks. A `half_period` of 0 behaves as 1.
- R4: A WRITE has the following behaviour:
  - It shifts `cmd_wdata` out MSB first, one bit per clock pulse, and `bus_dout` is stable while `bus_clk` is high.
  - A ninth pulse follows, during which `bus_dout` is held high.
  - `bus_din` is sampled at the end of that ninth high phase, and `ack_ok` reports 1 when the sample was low.
- R5: A READ has the following behaviour:
  - It samples `bus_din` at the end of each of eight high phases, MSB first, and presents the byte on `rdata` with `done`.
  - On the ninth pulse the master drives `bus_dout` low (acknowledge) when `cmd_nack` = 0, or high when `cmd_nack` = 1.
  - `ack_ok` reports `!cmd_nack`.
- R6: A START issued while a transaction is open makes a repeated start. `bus_dout` rises with `bus_clk` low, then `bus_clk` rises, then `bus_dout` falls while `bus_clk` is high, then `bus_clk` falls.
- R7: A STOP issued while a transaction is open drives `bus_dout` low with `bus_clk` low, then raises `bus_clk`, then raises `bus_dout` while `bus_clk` is high. Afterwards both lines stay high and the bus is idle.
- R8: While a transaction is open and `bus_side` is high with `bus_clk` low, `bus_clk` stays low and sequencing pauses. After release the transfer resumes and produces the same byte and status.
- R9: While the bus is idle, a high `bus_side` that follows a low sample taken during idle sets `alert_irq`. The flag stays set after `bus_side` drops.
- R10: A pulse on `alert_clr` clears `alert_irq`. If a new alert is detected in the same cycle, the set wins.
- R11: A `bus_side` assertion that starts while a transaction is open never raises `alert_irq`, even if it is still held after the stop. Detection re-arms only once `bus_side` is seen low while idle. A clear while `bus_side` stays high is therefore final.
- R12: A command is taken only in a cycle where `busy` is low. A command presented while `busy` is high is dropped and does not alter the running transfer.
- R13: A WRITE, READ or STOP issued with no transaction open, or any other command code, pulses `done` in the next cycle and leaves both bus lines unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| half_period | input | DIV_W | System clocks per half bus-clock period |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Command code |
| cmd_wdata | input | 8 | Byte to send for WRITE |
| cmd_nack | input | 1 | For READ: 1 sends NACK instead of ACK |
| busy | output | 1 | A command is executing |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Byte received by the last READ |
| ack_ok | output | 1 | Acknowledge status of the last byte |
| alert_clr | input | 1 | Write-one-to-clear for the alert flag |
| alert_irq | output | 1 | Sticky slave alert, level interrupt |
| bus_clk | output | 1 | Bus clock, push-pull |
| bus_dout | output | 1 | Bus data from master, push-pull |
| bus_din | input | 1 | Bus data from slave |
| bus_side | input | 1 | Slave sideband: alert when idle, clock hold when open |

## Verification
The bench stretches the clock in the middle of a byte and checks that the clock stays low and the byte is still correct. A design that sampled or shifted during the hold would corrupt the data or emit a clock edge.

It raises the sideband line inside a stop and keeps it held into idle. A design that treated any idle high level as an alert would raise a false interrupt there.

It also covers the following:
- A clear while the line stays high. Wrong re-arm logic would set the alert again.
- A clear that coincides with a new alert. Wrong priority would lose the event.
- Commands issued while busy or while no transaction is open. A design that took them would emit stray edges or start a second byte.
- A half period of zero and a repeated start after a read acknowledge.

// File: rtl/ptp_smb_master.sv
module ptp_smb_master #(
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] half_period,
  input  logic             cmd_valid,
  input  logic [2:0]       cmd_op,
  input  logic [7:0]       cmd_wdata,
  input  logic             cmd_nack,
  output logic             busy,
  output logic             done,
  output logic [7:0]       rdata,
  output logic             ack_ok,
  input  logic             alert_clr,
  output logic             alert_irq,
  output logic             bus_clk,
  output logic             bus_dout,
  input  logic             bus_din,
  input  logic             bus_side
);

  localparam logic [2:0] OP_START = 3'd1;
  localparam logic [2:0] OP_STOP  = 3'd2;
  localparam logic [2:0] OP_WRITE = 3'd3;
  localparam logic [2:0] OP_READ  = 3'd4;
  localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

  typedef enum logic [3:0] {
    S_IDLE, S_RS1, S_RS2, S_ST1, S_ST2, S_LO, S_HI, S_SP1, S_SP2, S_SP3
  } st_t;

  st_t             st;
  logic [DIV_W-1:0] cnt;
  logic            scl_q, sda_q, active_q, rd_q, nack_q;
  logic [3:0]      bitn;
  logic [7:0]      sh, rdata_q;
  logic            done_q, ack_q, alert_q, armed_q;

  wire [DIV_W-1:0] reload = (half_period == '0) ? '0 : half_period - ONE;
  wire stall     = active_q && bus_side && !scl_q;
  wire tick      = (st != S_IDLE) && !stall && (cnt == '0);
  wire accept    = cmd_valid && (st == S_IDLE);
  wire alert_set = !active_q && armed_q && bus_side;

  assign busy      = (st != S_IDLE);
  assign done      = done_q;
  assign rdata     = rdata_q;
  assign ack_ok    = ack_q;
  assign alert_irq = alert_q;
  assign bus_clk   = scl_q;
  assign bus_dout  = sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cnt      <= '0;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
      active_q <= 1'b0;
      rd_q     <= 1'b0;
      nack_q   <= 1'b0;
      bitn     <= '0;
      sh       <= '0;
      rdata_q  <= '0;
      done_q   <= 1'b0;
      ack_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (st != S_IDLE && !stall && cnt != '0) cnt <= cnt - ONE;
      if (accept) begin
        cnt <= reload;
        case (cmd_op)
          OP_START: begin
            if (active_q) begin
              sda_q <= 1'b1;
              st    <= S_RS1;
            end else begin
              sda_q    <= 1'b0;
              active_q <= 1'b1;
              st       <= S_ST1;
            end
          end
          OP_WRITE, OP_READ: begin
            if (active_q) begin
              rd_q   <= (cmd_op == OP_READ);
              nack_q <= cmd_nack;
              sh     <= cmd_wdata;
              bitn   <= '0;
              sda_q  <= (cmd_op == OP_READ) ? 1'b1 : cmd_wdata[7];
              st     <= S_LO;
            end else begin
              done_q <= 1'b1;
            end
          end
          OP_STOP: begin
            if (active_q) begin
              sda_q <= 1'b0;
              st    <= S_SP1;
            end else begin
              done_q <= 1'b1;
            end
          end
          default: done_q <= 1'b1;
        endcase
      end else if (tick) begin
        cnt <= reload;
        case (st)
          S_RS1: begin scl_q <= 1'b1; st <= S_RS2; end
          S_RS2: begin sda_q <= 1'b0; st <= S_ST1; end
          S_ST1: begin scl_q <= 1'b0; st <= S_ST2; end
          S_ST2: begin done_q <= 1'b1; st <= S_IDLE; end
          S_LO:  begin scl_q <= 1'b1; st <= S_HI; end
          S_HI: begin
            scl_q <= 1'b0;
            if (bitn == 4'd8) begin
              ack_q  <= rd_q ? !nack_q : !bus_din;
              if (rd_q) rdata_q <= sh;
              done_q <= 1'b1;
              st     <= S_IDLE;
            end else begin
              sh   <= {sh[6:0], bus_din};
              bitn <= bitn + 4'd1;
              if (bitn == 4'd7) sda_q <= rd_q ? nack_q : 1'b1;
              else              sda_q <= rd_q ? 1'b1 : sh[6];
              st <= S_LO;
            end
          end
          S_SP1: begin scl_q <= 1'b1; st <= S_SP2; end
          S_SP2: begin sda_q <= 1'b1; active_q <= 1'b0; st <= S_SP3; end
          S_SP3: begin done_q <= 1'b1; st <= S_IDLE; end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alert_q <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      if (active_q)       armed_q <= 1'b0;
      else if (!bus_side) armed_q <= 1'b1;
      else if (alert_set) armed_q <= 1'b0;
      if (alert_set)      alert_q <= 1'b1;
      else if (alert_clr) alert_q <= 1'b0;
    end
  end

  // R8
  stretch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && bus_side && !scl_q) |=> !scl_q);

  // R4
  dout_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_HI && $past(st == S_HI)) |-> $stable(sda_q));

  // R7
  idle_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && !active_q) |-> (scl_q && sda_q));

  // R12
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !busy);

  // R11
  alert_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alert_q) |-> !$past(active_q));

  // R10
  alert_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(alert_clr) && !$past(alert_set)) |-> !alert_q);

endmodule

// File: tb/sim_ptp_smb_master.sv
module sim_ptp_smb_master;
  localparam int CLK_NS = 10;
  localparam logic [2:0] C_START = 3'd1, C_STOP = 3'd2, C_WRITE = 3'd3, C_READ = 3'd4;
  // fields: [10] read, [9:2] byte, [1] write: slave acks / read: master nacks, [0] stop after
  localparam logic [10:0] VEC [6] = '{
    11'b0_10100101_1_0, 11'b1_00111100_0_1, 11'b0_00000000_0_1,
    11'b1_11111111_1_0, 11'b0_10000001_1_1, 11'b1_01011010_0_1};

  logic clk = 0, rst_n = 0;
  logic [11:0] hp = 12'd4;
  logic cmd_valid = 0, cmd_nack = 0, alert_clr = 0, bus_side = 0;
  logic [2:0] cmd_op = 0;
  logic [7:0] cmd_wdata = 0;
  logic busy, done, ack_ok, alert_irq, bus_clk, bus_dout, bus_din;
  logic [7:0] rdata;

  int checks = 0, errs = 0;
  int n_start = 0, n_stop = 0, fcnt = 0, fbase = 0;
  int hi_run = 0, lo_run = 0, last_hi = 0, last_lo = 0;
  logic prev_c = 1, prev_d = 1;
  logic [15:0] hist = 0;
  logic s_rd = 0, s_ack_low = 1;
  logic [7:0] s_byte = 0;

  ptp_smb_master #(.DIV_W(12)) u0 (
    .clk(clk), .rst_n(rst_n), .half_period(hp), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_wdata(cmd_wdata), .cmd_nack(cmd_nack), .busy(busy), .done(done), .rdata(rdata),
    .ack_ok(ack_ok), .alert_clr(alert_clr), .alert_irq(alert_irq), .bus_clk(bus_clk),
    .bus_dout(bus_dout), .bus_din(bus_din), .bus_side(bus_side));

  always #(CLK_NS/2) clk = ~clk;

  always @(negedge clk) begin
    if (prev_c && bus_clk && prev_d && !bus_dout) n_start++;
    if (prev_c && bus_clk && !prev_d && bus_dout) n_stop++;
    if (!prev_c && bus_clk) begin hist = {hist[14:0], bus_dout}; last_lo = lo_run; end
    if (prev_c && !bus_clk) begin fcnt++; last_hi = hi_run; end
    if (bus_clk) begin hi_run = prev_c ? hi_run + 1 : 1; lo_run = 0; end
    else begin lo_run = prev_c ? 1 : lo_run + 1; hi_run = 0; end
    prev_c = bus_clk;
    prev_d = bus_dout;
  end

  always_comb begin
    int k;
    k = fcnt - fbase;
    if (k < 8) bus_din = s_rd ? s_byte[3'(7 - k)] : 1'b1;
    else       bus_din = !s_ack_low;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] op, input logic [7:0] d, input logic nk);
    @(negedge clk);
    cmd_valid = 1; cmd_op = op; cmd_wdata = d; cmd_nack = nk;
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic wait_done();
    int t = 0;
    while (!done && t < 20000) begin @(negedge clk); t++; end
    @(negedge clk);
  endtask

  task automatic run(input logic [2:0] op, input logic [7:0] d, input logic nk);
    issue(op, d, nk);
    wait_done();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
    $finish;
  end

  initial begin
    int ns, np;
    logic open;
    logic [10:0] v;
    repeat (4) @(negedge clk);
    // R1 during reset
    chk(bus_clk && bus_dout && !busy && !done && !alert_irq, "R1 reset", {bus_clk, bus_dout, busy}, 3'b110);
    rst_n = 1;
    @(negedge clk);
    chk(bus_clk && bus_dout && !busy && !alert_irq, "R1 after reset", {bus_clk, bus_dout, busy}, 3'b110);

    open = 0;
    for (int i = 0; i < 6; i++) begin
      v = VEC[i];
      ns = n_start;
      run(C_START, 8'h00, 1'b0);
      chk(n_start == ns + 1 && !bus_clk, open ? "R6 repeated start" : "R2 start", n_start - ns, 1);
      s_rd = v[10]; s_byte = v[9:2]; s_ack_low = v[1]; fbase = fcnt;
      run(v[10] ? C_READ : C_WRITE, v[9:2], v[1]);
      if (v[10]) begin
        chk(rdata == v[9:2], "R5 read byte", rdata, v[9:2]);
        chk(hist[0] == v[1] && ack_ok == !v[1], "R5 master ack bit", {hist[0], ack_ok}, {v[1], !v[1]});
      end else begin
        chk(hist[8:1] == v[9:2], "R4 written byte", hist[8:1], v[9:2]);
        chk(ack_ok == v[1] && hist[0], "R4 ack status", ack_ok, v[1]);
      end
      chk(last_hi == int'(hp) && last_lo == int'(hp), "R3 phase width", last_hi, hp);
      open = 1;
      if (v[0]) begin
        np = n_stop;
        run(C_STOP, 8'h00, 1'b0);
        chk(n_stop == np + 1 && bus_clk && bus_dout, "R7 stop", n_stop - np, 1);
        open = 0;
      end
    end

    // R3: zero half period acts as one
    hp = 12'd0;
    run(C_START, 8'h00, 1'b0);
    s_rd = 0; s_ack_low = 1; fbase = fcnt;
    run(C_WRITE, 8'h6B, 1'b0);
    chk(last_hi == 1 && last_lo == 1 && hist[8:1] == 8'h6B, "R3 zero divider", last_hi, 1);
    run(C_STOP, 8'h00, 1'b0);

    // R8: clock stretch mid-byte
    hp = 12'd2;
    run(C_START, 8'h00, 1'b0);
    s_rd = 0; s_ack_low = 1; fbase = fcnt;
    issue(C_WRITE, 8'hC3, 1'b0);
    @(negedge bus_clk);
    @(negedge clk);
    bus_side = 1;
    begin
      int hi_seen = 0;
      for (int j = 0; j < 20; j++) begin @(negedge clk); if (bus_clk) hi_seen++; end
      chk(hi_seen == 0, "R8 clock held low", hi_seen, 0);
    end
    chk(!alert_irq, "R11 no alert during transfer", alert_irq, 0);
    bus_side = 0;
    wait_done();
    chk(hist[8:1] == 8'hC3 && ack_ok, "R8 byte after stretch", hist[8:1], 8'hC3);

    // R11: sideband raised inside stop, held into idle
    issue(C_STOP, 8'h00, 1'b0);
    @(posedge bus_clk);
    @(negedge clk);
    bus_side = 1;
    wait_done();
    repeat (5) @(negedge clk);
    chk(!alert_irq && bus_clk && bus_dout, "R11 held past stop", alert_irq, 0);
    bus_side = 0;
    repeat (3) @(negedge clk);
    chk(!alert_irq, "R11 release no alert", alert_irq, 0);
    bus_side = 1;
    repeat (3) @(negedge clk);
    chk(alert_irq, "R9 idle alert", alert_irq, 1);
    bus_side = 0;
    repeat (3) @(negedge clk);
    chk(alert_irq, "R9 sticky", alert_irq, 1);
    alert_clr = 1; @(negedge clk); alert_clr = 0; @(negedge clk);
    chk(!alert_irq, "R10 clear", alert_irq, 0);
    bus_side = 1;
    repeat (3) @(negedge clk);
    alert_clr = 1; @(negedge clk); alert_clr = 0;
    repeat (4) @(negedge clk);
    chk(!alert_irq, "R11 clear while held stays clear", alert_irq, 0);
    bus_side = 0;
    repeat (3) @(negedge clk);
    bus_side = 1; alert_clr = 1;
    @(negedge clk);
    alert_clr = 0;
    @(negedge clk);
    chk(alert_irq, "R10 set beats clear", alert_irq, 1);
    bus_side = 0;
    alert_clr = 1; @(negedge clk); alert_clr = 0; @(negedge clk);

    // R13: commands with no open transaction
    ns = n_start;
    issue(C_WRITE, 8'h00, 1'b0);
    chk(done && !busy && bus_clk && bus_dout, "R13 write while idle", {done, bus_clk, bus_dout}, 3'b111);
    issue(C_STOP, 8'h00, 1'b0);
    chk(done && bus_clk && bus_dout, "R13 stop while idle", {done, bus_clk, bus_dout}, 3'b111);
    issue(3'd7, 8'h00, 1'b0);
    chk(done && bus_clk && bus_dout && n_start == ns, "R13 unknown code", n_start - ns, 0);

    // R12: command while busy dropped
    hp = 12'd3;
    run(C_START, 8'h00, 1'b0);
    s_rd = 0; s_ack_low = 1; fbase = fcnt;
    issue(C_WRITE, 8'h96, 1'b0);
    repeat (3) @(negedge clk);
    cmd_valid = 1; cmd_op = C_READ; cmd_wdata = 8'h11;
    repeat (2) @(negedge clk);
    cmd_valid = 0;
    wait_done();
    chk(hist[8:1] == 8'h96, "R12 byte unaffected", hist[8:1], 8'h96);
    begin
      int rises = 0;
      logic pc = bus_clk;
      for (int j = 0; j < 12; j++) begin @(negedge clk); if (!pc && bus_clk) rises++; pc = bus_clk; end
      chk(rises == 0 && !busy, "R12 no second command", rises, 0);
    end
    run(C_STOP, 8'h00, 1'b0);
    chk(bus_clk && bus_dout && !alert_irq, "R7 final idle", {bus_clk, bus_dout}, 2'b11);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
    $finish;
  end
endmodule